// File: doc/BRIEF.md
# Write-Back Two-Way Data Cache

This block is a small first-level data cache placed between a processor load/store port and a next-level memory that moves whole blocks. It is two-way set-associative and uses a write-back, write-allocate policy. Each line holds four 32-bit words (16 bytes). A request address splits into a word select inside the line, a set index and a tag. Both ways of the indexed set are compared in parallel. A load hit returns the selected word through a way multiplexer. A store hit is merged into its line and marks the line dirty.

On a miss, the cache picks a victim way in the set. An invalid way is used first; otherwise the least recently used way is chosen. A dirty victim is sent to the next level as a full-line write before the read request goes out. The next level returns the line one word per beat, starting with the requested word and wrapping around. A load gets that first word on the processor response port straight away, while the rest of the line is still filling. A store miss installs the whole line first and then does its word write.

Only one miss is handled at a time. The processor port takes no new request until the current one has completely finished.

Top module: `dcache_wb`

## Requirements
- R1: Address fields are fixed. Bits [3:2] select the word, bits [IDX_W+3:4] select one of SETS sets, and the bits above form the tag. Lines in one set never disturb lines in another set.
- R2: A load that hits returns its word in the cycle after acceptance and makes no memory request.
- R3: A store that hits uses a tag-check cycle and then a write cycle. Its acknowledge comes one cycle later than a load hit. It makes no memory request. Later loads return the stored word.
- R4: A load miss issues one read request whose address is the request address with bits [1:0] cleared. The requested word is returned on the first refill beat, while `cpu_stall` is still high.
- R5: Refill beats arrive in wrap order, starting at the requested word. The four beats fill word positions w, w+1, w+2, w+3 (mod 4), so every word of the line then hits with the correct data.
- R6: A store miss fetches the line, installs it and then writes the word. The line is left dirty, so evicting it later writes the stored word back.
- R7: When the victim is dirty, a write request carrying the whole 128-bit victim line goes out first, at the victim's block-aligned address (word k in bits [32k+31:32k]). The read request follows it.
- R8: A write request is issued only for a victim that is both valid and dirty. Clean or invalid victims cause no writeback.
- R9: The victim is an invalid way if one exists. Otherwise it is the way of the set that was used least recently. Every hit, fill or store marks its way as most recently used.
- R10: After reset all lines are invalid and clean. `cpu_req_ready` is high, and `cpu_stall`, `cpu_rsp_valid` and `mem_req_valid` are low.
- R11: Once a request is accepted, `cpu_req_ready` stays low until the request completes, including the refill that follows a forwarded word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req_valid | input | 1 | Processor request present |
| cpu_req_ready | output | 1 | Cache can accept a request |
| cpu_req_write | input | 1 | 1 = store, 0 = load |
| cpu_req_addr | input | 32 | Byte address |
| cpu_req_wdata | input | 32 | Store data |
| cpu_rsp_valid | output | 1 | Load data or store acknowledge |
| cpu_rsp_rdata | output | 32 | Load data |
| cpu_stall | output | 1 | Miss in progress |
| mem_req_valid | output | 1 | Next-level request present |
| mem_req_ready | input | 1 | Next level accepts request |
| mem_req_write | output | 1 | 1 = line writeback, 0 = line read |
| mem_req_addr | output | 32 | Block-aligned write address or word-aligned read address |
| mem_req_wdata | output | 128 | Victim line for a writeback |
| mem_rsp_valid | input | 1 | One refill word present |
| mem_rsp_rdata | input | 32 | Refill word |

## Verification
Loads are issued at three word positions of one line after a cold miss. This separates a correct wrap-order refill from one that writes beats in plain order. Refills starting at word 2 and at word 3 confirm the placement.

Conflicting tags in a single set are accessed in an order that fills the invalid way first. A touched line must then survive, and a clean victim must leave without a writeback. A dirty victim must then produce a write followed by a read.

A store miss in a second set is later evicted. This tells a write-allocate that keeps the dirty mark apart from one that loses it, and shows the first set was left alone.

// File: rtl/dcache_pkg.sv
package dcache_pkg;

    localparam int ADDR_W     = 32;
    localparam int WORD_W     = 32;
    localparam int LINE_WORDS = 4;
    localparam int WSEL_W     = $clog2(LINE_WORDS);
    localparam int OFF_W      = WSEL_W + 2;
    localparam int LINE_W     = WORD_W * LINE_WORDS;
    localparam int NWAYS      = 2;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOOK,
        ST_STORE,
        ST_EVICT,
        ST_FETCH,
        ST_FILL
    } ctl_state_t;

    typedef struct packed {
        logic              write;
        logic [ADDR_W-1:0] addr;
        logic [WORD_W-1:0] wdata;
    } cpu_req_t;

    function automatic logic [WORD_W-1:0] pick_word(input logic [LINE_W-1:0] line,
                                                    input logic [WSEL_W-1:0] sel);
        return line[sel*WORD_W +: WORD_W];
    endfunction

endpackage

// File: rtl/dc_way.sv
module dc_way
    import dcache_pkg::*;
#(
    parameter int SETS  = 8,
    parameter int IDX_W = 3,
    parameter int TAG_W = 25
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [IDX_W-1:0]  idx,
    output logic              line_valid,
    output logic              line_dirty,
    output logic [TAG_W-1:0]  line_tag,
    output logic [LINE_W-1:0] line_data,
    input  logic              word_we,
    input  logic [WSEL_W-1:0] word_sel,
    input  logic [WORD_W-1:0] word_in,
    input  logic              mark_dirty,
    input  logic              install,
    input  logic [TAG_W-1:0]  install_tag
);

    logic [SETS-1:0]   valid_q;
    logic [SETS-1:0]   dirty_q;
    logic [TAG_W-1:0]  tag_q  [SETS];
    logic [LINE_W-1:0] data_q [SETS];

    assign line_valid = valid_q[idx];
    assign line_dirty = dirty_q[idx];
    assign line_tag   = tag_q[idx];
    assign line_data  = data_q[idx];

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= '0;
            dirty_q <= '0;
        end else if (install) begin
            valid_q[idx] <= 1'b1;
            dirty_q[idx] <= 1'b0;
        end else if (word_we && mark_dirty) begin
            dirty_q[idx] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (install) begin
            tag_q[idx] <= install_tag;
        end
        if (word_we) begin
            data_q[idx][word_sel*WORD_W +: WORD_W] <= word_in;
        end
    end

    AST_INSTALL_CLEAN: assert property (@(posedge clk) disable iff (rst)
        install |=> (valid_q[$past(idx)] && !dirty_q[$past(idx)])); // R5
    AST_STORE_DIRTY: assert property (@(posedge clk) disable iff (rst)
        (word_we && mark_dirty) |=> dirty_q[$past(idx)]); // R3

endmodule

// File: rtl/dc_lru.sv
module dc_lru #(
    parameter int SETS  = 8,
    parameter int IDX_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IDX_W-1:0] idx,
    input  logic             touch,
    input  logic             touch_way,
    output logic             lru_way
);

    logic [SETS-1:0] lru_q;

    assign lru_way = lru_q[idx];

    always_ff @(posedge clk) begin
        if (rst) begin
            lru_q <= '0;
        end else if (touch) begin
            lru_q[idx] <= ~touch_way;
        end
    end

    AST_LRU_OTHER: assert property (@(posedge clk) disable iff (rst)
        touch |=> (lru_q[$past(idx)] != $past(touch_way))); // R9

endmodule

// File: rtl/dc_lookup.sv
module dc_lookup
    import dcache_pkg::*;
#(
    parameter int TAG_W = 25
) (
    input  logic [NWAYS-1:0]  vld,
    input  logic [TAG_W-1:0]  tags  [NWAYS],
    input  logic [LINE_W-1:0] lines [NWAYS],
    input  logic [TAG_W-1:0]  addr_tag,
    input  logic [WSEL_W-1:0] wsel,
    output logic [NWAYS-1:0]  match,
    output logic              hit,
    output logic              hit_way,
    output logic [WORD_W-1:0] hit_word
);

    for (genvar g = 0; g < NWAYS; g++) begin : g_cmp
        assign match[g] = vld[g] && (tags[g] == addr_tag);
    end

    assign hit      = |match;
    assign hit_way  = match[1];
    assign hit_word = pick_word(lines[hit_way], wsel);

endmodule

// File: rtl/dcache_wb.sv
module dcache_wb
    import dcache_pkg::*;
#(
    parameter int SETS = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cpu_req_valid,
    output logic              cpu_req_ready,
    input  logic              cpu_req_write,
    input  logic [ADDR_W-1:0] cpu_req_addr,
    input  logic [WORD_W-1:0] cpu_req_wdata,
    output logic              cpu_rsp_valid,
    output logic [WORD_W-1:0] cpu_rsp_rdata,
    output logic              cpu_stall,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic              mem_req_write,
    output logic [ADDR_W-1:0] mem_req_addr,
    output logic [LINE_W-1:0] mem_req_wdata,
    input  logic              mem_rsp_valid,
    input  logic [WORD_W-1:0] mem_rsp_rdata
);

    localparam int IDX_W = $clog2(SETS);
    localparam int TAG_W = ADDR_W - IDX_W - OFF_W;

    ctl_state_t        st_q;
    cpu_req_t          rq_q;
    logic              tgt_q;
    logic [WSEL_W-1:0] beat_q;

    logic [TAG_W-1:0]  rq_tag;
    logic [IDX_W-1:0]  rq_idx;
    logic [WSEL_W-1:0] rq_wsel;

    assign rq_tag  = rq_q.addr[ADDR_W-1 -: TAG_W];
    assign rq_idx  = rq_q.addr[OFF_W +: IDX_W];
    assign rq_wsel = rq_q.addr[2 +: WSEL_W];

    logic [NWAYS-1:0]  way_vld;
    logic [NWAYS-1:0]  way_drt;
    logic [TAG_W-1:0]  way_tag  [NWAYS];
    logic [LINE_W-1:0] way_line [NWAYS];
    logic [NWAYS-1:0]  way_we;
    logic [NWAYS-1:0]  way_inst;
    logic [WSEL_W-1:0] word_sel;
    logic [WORD_W-1:0] word_in;
    logic              mark_dirty;

    for (genvar g = 0; g < NWAYS; g++) begin : g_way
        dc_way #(.SETS(SETS), .IDX_W(IDX_W), .TAG_W(TAG_W)) u_way (
            .clk        (clk),
            .rst        (rst),
            .idx        (rq_idx),
            .line_valid (way_vld[g]),
            .line_dirty (way_drt[g]),
            .line_tag   (way_tag[g]),
            .line_data  (way_line[g]),
            .word_we    (way_we[g]),
            .word_sel   (word_sel),
            .word_in    (word_in),
            .mark_dirty (mark_dirty),
            .install    (way_inst[g]),
            .install_tag(rq_tag)
        );
    end

    logic [NWAYS-1:0]  match;
    logic              hit;
    logic              hit_way;
    logic [WORD_W-1:0] hit_word;

    dc_lookup #(.TAG_W(TAG_W)) u_lookup (
        .vld     (way_vld),
        .tags    (way_tag),
        .lines   (way_line),
        .addr_tag(rq_tag),
        .wsel    (rq_wsel),
        .match   (match),
        .hit     (hit),
        .hit_way (hit_way),
        .hit_word(hit_word)
    );

    logic touch;
    logic touch_way;
    logic lru_way;

    dc_lru #(.SETS(SETS), .IDX_W(IDX_W)) u_lru (
        .clk      (clk),
        .rst      (rst),
        .idx      (rq_idx),
        .touch    (touch),
        .touch_way(touch_way),
        .lru_way  (lru_way)
    );

    logic vic_way;
    assign vic_way = !way_vld[0] ? 1'b0 :
                     !way_vld[1] ? 1'b1 : lru_way;

    assign cpu_req_ready = (st_q == ST_IDLE);
    assign cpu_stall     = (st_q == ST_EVICT) || (st_q == ST_FETCH) || (st_q == ST_FILL);
    assign mem_req_wdata = way_line[tgt_q];

    always_comb begin
        cpu_rsp_valid = 1'b0;
        cpu_rsp_rdata = '0;
        mem_req_valid = 1'b0;
        mem_req_write = 1'b0;
        mem_req_addr  = '0;
        way_we        = '0;
        way_inst      = '0;
        word_sel      = rq_wsel;
        word_in       = rq_q.wdata;
        mark_dirty    = 1'b0;
        touch         = 1'b0;
        touch_way     = tgt_q;
        case (st_q)
            ST_LOOK: begin
                if (hit && !rq_q.write) begin
                    cpu_rsp_valid = 1'b1;
                    cpu_rsp_rdata = hit_word;
                    touch         = 1'b1;
                    touch_way     = hit_way;
                end
            end
            ST_STORE: begin
                way_we[tgt_q] = 1'b1;
                mark_dirty    = 1'b1;
                touch         = 1'b1;
                cpu_rsp_valid = 1'b1;
            end
            ST_EVICT: begin
                mem_req_valid = 1'b1;
                mem_req_write = 1'b1;
                mem_req_addr  = {way_tag[tgt_q], rq_idx, {OFF_W{1'b0}}};
            end
            ST_FETCH: begin
                mem_req_valid = 1'b1;
                mem_req_addr  = rq_q.addr & ~ADDR_W'(3);
            end
            ST_FILL: begin
                if (mem_rsp_valid) begin
                    way_we[tgt_q] = 1'b1;
                    word_sel      = rq_wsel + beat_q;
                    word_in       = mem_rsp_rdata;
                    if (beat_q == '0 && !rq_q.write) begin
                        cpu_rsp_valid = 1'b1;
                        cpu_rsp_rdata = mem_rsp_rdata;
                    end
                    if (beat_q == WSEL_W'(LINE_WORDS - 1)) begin
                        way_inst[tgt_q] = 1'b1;
                        touch           = !rq_q.write;
                    end
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_IDLE;
            rq_q   <= '0;
            tgt_q  <= 1'b0;
            beat_q <= '0;
        end else begin
            case (st_q)
                ST_IDLE: begin
                    if (cpu_req_valid) begin
                        rq_q <= '{write: cpu_req_write, addr: cpu_req_addr, wdata: cpu_req_wdata};
                        st_q <= ST_LOOK;
                    end
                end
                ST_LOOK: begin
                    if (hit) begin
                        tgt_q <= hit_way;
                        st_q  <= rq_q.write ? ST_STORE : ST_IDLE;
                    end else begin
                        tgt_q <= vic_way;
                        st_q  <= (way_vld[vic_way] && way_drt[vic_way]) ? ST_EVICT : ST_FETCH;
                    end
                end
                ST_STORE: st_q <= ST_IDLE;
                ST_EVICT: if (mem_req_ready) st_q <= ST_FETCH;
                ST_FETCH: begin
                    if (mem_req_ready) begin
                        beat_q <= '0;
                        st_q   <= ST_FILL;
                    end
                end
                ST_FILL: begin
                    if (mem_rsp_valid) begin
                        beat_q <= beat_q + WSEL_W'(1);
                        if (beat_q == WSEL_W'(LINE_WORDS - 1)) begin
                            st_q <= rq_q.write ? ST_STORE : ST_IDLE;
                        end
                    end
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    AST_ONE_MATCH: assert property (@(posedge clk) disable iff (rst)
        $onehot0(match)); // R2
    AST_WB_DIRTY_ONLY: assert property (@(posedge clk) disable iff (rst)
        (mem_req_valid && mem_req_write) |-> (way_vld[tgt_q] && way_drt[tgt_q])); // R8
    AST_READ_AFTER_WB: assert property (@(posedge clk) disable iff (rst)
        (mem_req_valid && mem_req_write && mem_req_ready) |=> (mem_req_valid && !mem_req_write)); // R7
    AST_HOLD_OFF: assert property (@(posedge clk) disable iff (rst)
        (cpu_req_valid && cpu_req_ready) |=> !cpu_req_ready); // R11

endmodule

// File: tb/test_dcache_wb.sv
`timescale 1ns/1ps
module test_dcache_wb;
    import dcache_pkg::*;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              cpu_req_valid = 1'b0;
    logic              cpu_req_ready;
    logic              cpu_req_write = 1'b0;
    logic [31:0]       cpu_req_addr = '0;
    logic [31:0]       cpu_req_wdata = '0;
    logic              cpu_rsp_valid;
    logic [31:0]       cpu_rsp_rdata;
    logic              cpu_stall;
    logic              mem_req_valid;
    logic              mem_req_ready = 1'b0;
    logic              mem_req_write;
    logic [31:0]       mem_req_addr;
    logic [127:0]      mem_req_wdata;
    logic              mem_rsp_valid = 1'b0;
    logic [31:0]       mem_rsp_rdata = '0;

    dcache_wb #(.SETS(8)) i_dcache_wb (.*);

    always #2.5 clk = ~clk;

    typedef struct {
        logic        w;
        logic [31:0] d;
        string       tag;
    } exp_t;

    exp_t        exp_q[$];
    logic [31:0] back [1024];
    logic [31:0] refm [1024];
    logic        op_w_q[$];
    logic [31:0] op_a_q[$];
    int checks = 0, failures = 0, cyc = 0;
    int rd_ops = 0, wr_ops = 0, rsp_cnt = 0, rsp_cyc = 0;
    logic rsp_stall = 1'b0, rsp_ready = 1'b0;
    bit done = 0;

    function automatic logic [31:0] seed_word(input int i);
        return 32'h5A00_0000 + i * 32'h0001_0003;
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    always @(posedge clk) cyc <= cyc + 1;

    // scoreboard monitor
    always @(negedge clk) begin
        if (!rst && cpu_rsp_valid) begin
            if (exp_q.size() == 0) begin
                chk(0, "R11 response with nothing outstanding", cpu_rsp_rdata, 0);
            end else begin
                exp_t it;
                it = exp_q.pop_front();
                if (!it.w) chk(cpu_rsp_rdata == it.d, it.tag, cpu_rsp_rdata, it.d);
            end
            rsp_cyc   = cyc;
            rsp_stall = cpu_stall;
            rsp_ready = cpu_req_ready;
            rsp_cnt++;
        end
    end

    // next-level memory model
    initial begin
        for (int i = 0; i < 1024; i++) begin
            back[i] = seed_word(i);
            refm[i] = seed_word(i);
        end
        forever begin
            @(negedge clk);
            if (mem_req_valid === 1'b1) begin
                logic        w;
                logic [31:0] a;
                logic [127:0] ln;
                repeat (2) @(negedge clk);
                w = mem_req_write;
                a = mem_req_addr;
                ln = mem_req_wdata;
                mem_req_ready = 1'b1;
                @(negedge clk);
                mem_req_ready = 1'b0;
                op_w_q.push_back(w);
                op_a_q.push_back(a);
                if (w) begin
                    wr_ops++;
                    for (int k = 0; k < 4; k++) back[int'(a[11:4]) * 4 + k] = ln[k*32 +: 32];
                end else begin
                    rd_ops++;
                    repeat (2) @(negedge clk);
                    for (int k = 0; k < 4; k++) begin
                        mem_rsp_valid = 1'b1;
                        mem_rsp_rdata = back[int'(a[11:4]) * 4 + ((int'(a[3:2]) + k) % 4)];
                        @(negedge clk);
                    end
                    mem_rsp_valid = 1'b0;
                end
            end
        end
    end

    // driver: pushes the expected item, then waits for the response
    task automatic access(input logic w, input logic [31:0] a, input logic [31:0] d,
                          input string tag, output int lat);
        int n0, acc;
        while (cpu_req_ready !== 1'b1) @(negedge clk);
        cpu_req_valid = 1'b1;
        cpu_req_write = w;
        cpu_req_addr  = a;
        cpu_req_wdata = d;
        exp_q.push_back('{w, w ? d : refm[a[11:2]], tag});
        if (w) refm[a[11:2]] = d;
        n0 = rsp_cnt;
        @(negedge clk);
        cpu_req_valid = 1'b0;
        acc = cyc;
        wait (rsp_cnt != n0);
        lat = rsp_cyc - acc;
    endtask

    task automatic settle();
        while (cpu_req_ready !== 1'b1) @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int lat, r0, w0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(cpu_req_ready === 1'b1 && cpu_stall === 1'b0, "R10 ready and not stalled after reset",
            {cpu_req_ready, cpu_stall}, 2'b10);
        chk(mem_req_valid === 1'b0 && cpu_rsp_valid === 1'b0, "R10 quiet ports after reset",
            {mem_req_valid, cpu_rsp_valid}, 0);

        // cold load miss at word 2
        r0 = rd_ops; w0 = wr_ops;
        access(0, 32'h008, 0, "R4 forwarded load-miss data", lat);
        chk(rsp_stall == 1'b1, "R4 word forwarded while refill pending", rsp_stall, 1);
        chk(rsp_ready == 1'b0, "R11 new requests held off during refill", rsp_ready, 0);
        settle();
        chk(rd_ops - r0 == 1, "R10 lines invalid after reset so first access reads", rd_ops - r0, 1);
        chk(wr_ops == w0, "R8 invalid victim not written back", wr_ops - w0, 0);
        chk(op_a_q[$] == 32'h008, "R4 word-aligned read address", op_a_q[$], 32'h008);

        // rest of the line hits (wrap-order refill)
        access(0, 32'h000, 0, "R5 word0 after wrap refill", lat);
        chk(lat == 0, "R2 load hit latency", lat, 0);
        access(0, 32'h004, 0, "R5 word1 after wrap refill", lat);
        access(0, 32'h00C, 0, "R5 word3 after wrap refill", lat);
        chk(lat == 0, "R2 load hit latency word3", lat, 0);
        chk(rd_ops - r0 == 1, "R2 hits make no memory request", rd_ops - r0, 1);

        // store hit
        access(1, 32'h004, 32'hDEAD_BEEF, "R3 store ack", lat);
        chk(lat == 1, "R3 store hit takes check plus write cycle", lat, 1);
        access(0, 32'h004, 0, "R3 stored word visible", lat);
        chk(rd_ops - r0 == 1 && wr_ops == w0, "R3 store hit makes no memory request", rd_ops - r0, 1);

        // second way of set 0 is invalid: filled without writeback
        r0 = rd_ops; w0 = wr_ops;
        access(0, 32'h080, 0, "R1 conflicting tag same set", lat);
        settle();
        chk(rd_ops - r0 == 1 && wr_ops == w0, "R9 invalid way used before eviction", wr_ops - w0, 0);
        access(0, 32'h000, 0, "R9 first line kept", lat);
        chk(lat == 0, "R9 first line still resident", lat, 0);

        // LRU is 0x080 (clean): evicted without writeback
        r0 = rd_ops; w0 = wr_ops;
        access(0, 32'h100, 0, "R9 third tag load", lat);
        settle();
        chk(wr_ops == w0, "R8 clean victim not written back", wr_ops - w0, 0);
        access(0, 32'h004, 0, "R9 recently used dirty line kept", lat);
        chk(lat == 0, "R9 LRU way evicted, not the recent one", lat, 0);

        // now 0x100 is LRU: evict it (clean), then dirty 0x000 becomes victim
        access(0, 32'h080, 0, "R9 reload evicted line", lat);
        settle();
        r0 = rd_ops; w0 = wr_ops;
        access(0, 32'h188, 0, "R7 load after dirty eviction", lat);
        settle();
        chk(wr_ops - w0 == 1 && rd_ops - r0 == 1, "R7 one writeback and one read", wr_ops - w0, 1);
        chk(op_w_q[op_w_q.size()-2] == 1'b1 && op_w_q[$] == 1'b0, "R7 writeback precedes read",
            {op_w_q[op_w_q.size()-2], op_w_q[$]}, 2'b10);
        chk(op_a_q[op_a_q.size()-2] == 32'h000, "R7 writeback block address", op_a_q[op_a_q.size()-2], 32'h0);
        chk(back[1] == 32'hDEAD_BEEF, "R7 stored word written back", back[1], 32'hDEAD_BEEF);
        chk(back[2] == seed_word(2), "R7 untouched word written back", back[2], seed_word(2));

        // store miss in set 1
        r0 = rd_ops; w0 = wr_ops;
        access(1, 32'h21C, 32'h1234_5678, "R6 store miss ack", lat);
        settle();
        chk(rd_ops - r0 == 1 && wr_ops == w0, "R6 store miss fetches line", rd_ops - r0, 1);
        access(0, 32'h21C, 0, "R6 store-miss word visible", lat);
        access(0, 32'h210, 0, "R6 rest of allocated line", lat);
        access(0, 32'h184, 0, "R1 other set untouched data", lat);
        chk(lat == 0, "R1 other set untouched", lat, 0);

        // evict the store-miss line
        access(0, 32'h29C, 0, "R6 fill second way of set 1", lat);
        settle();
        w0 = wr_ops;
        access(0, 32'h31C, 0, "R5 word3 forwarded first", lat);
        settle();
        chk(wr_ops - w0 == 1 && op_a_q[op_a_q.size()-2] == 32'h210, "R6 store-miss line left dirty",
            op_a_q[op_a_q.size()-2], 32'h210);
        chk(back[32'h21C >> 2] == 32'h1234_5678, "R6 written-back store data", back[32'h21C >> 2], 32'h1234_5678);
        access(0, 32'h310, 0, "R5 wrapped word0", lat);
        chk(lat == 0, "R5 wrapped line resident", lat, 0);
        access(0, 32'h314, 0, "R5 wrapped word1", lat);
        access(0, 32'h318, 0, "R5 wrapped word2", lat);

        repeat (4) @(negedge clk);
        chk(exp_q.size() == 0, "R11 every request answered once", exp_q.size(), 0);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule